// File: doc/BRIEF.md
# Dual-Request Interrupt Controller

This block gathers 32 interrupt sources and turns them into two request lines and a wake line. Each source has its own trigger mode: rising edge, falling edge, both edges, active-high level, active-low level or off. Each source also has a mask bit, a wake-enable bit, a routing bit that picks one of the two request lines, and a select bit that picks which of two input buses drives it. Software reaches every configuration register through a small word-addressed bus. Each register has its own set, clear and read address, so one source can change its bits without a read-modify-write.

Every input first passes a two-flop synchronizer. An edge-mode source records its events in a rising latch and a falling latch, and each latch stays set until software writes 1s to the matching clear address. A level-mode source follows the synchronized input with no latch. Software reads the two pending words, one for each request line, and finds out which routed, enabled sources are active.

Top module: `dual_req_intc`

## Requirements
- R1: After reset, the trigger-mode, select, wake and mask registers and both edge-latch words read 0. The routing register reads all ones. req0_o, req1_o and wake_o are low.
- R2: Configuration register k (0 = mode bit 0, 1 = mode bit 1, 2 = mode bit 2, 3 = input select, 4 = routing, 5 = wake enable, 6 = mask) is read at address 4k, set at 4k+1 and cleared at 4k+2. A 1 in the write data sets or clears that bit. A 0 leaves that bit unchanged.
- R3: The source's mode is {mode bit 2, mode bit 1, mode bit 0}. Code 001 latches only rising edges, 010 latches only falling edges, and 011 latches both. An edge the mode does not name sets no latch.
- R4: Code 101 makes the source active while its synchronized input is high, and code 110 while it is low. The request follows the input with two cycles of synchronizer delay and no latching.
- R5: An edge latch holds until 1s are written to the rising-clear address (29) or the falling-clear address (30). Rising latches read at 28 and falling latches at 31. A source in both-edges mode stays active until both of its latches are cleared.
- R6: Codes 000, 100 and 111 never make a source active, whatever its input does.
- R7: A source whose mask bit is 0 is absent from both pending words and cannot raise either request line.
- R8: A routing bit of 1 sends the source to req0_o, and 0 sends it to req1_o.
- R9: Address 32 reads the pending word for req0_o and address 33 the one for req1_o. Each shows active, unmasked sources routed to that line. Each request output is the OR of its word.
- R10: wake_o is the OR of active sources whose wake-enable bit is set, whatever their mask bit.
- R11: An input-select bit of 1 takes the source from src_a_i, and 0 takes it from src_b_i.
- R12: Writing 1 to bit 0 at address 37 enters test mode, which holds both request lines low. Writing 0 returns to normal operation. Address 36 reads the test bit.
- R13: Read data appears on bus_rdata_o on the clock edge that samples bus_rd_i, so one cycle after the strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_a_i | input | 32 | First source input bus |
| src_b_i | input | 32 | Second source input bus |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data, one bit per source |
| bus_rdata_o | output | 32 | Registered read data |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake output |

## Verification
The bench builds the block with its default of 32 sources, so the full address map is covered, including the edge-latch and pending words. A different source takes each scenario, so the routing and select bits are seen differing per source in the read-back words. Every trigger code is reached, among them the reserved codes 100 and 111, and each edge mode is driven through both input transitions.

// File: rtl/dual_req_intc.sv
module dual_req_intc #(
  parameter int N  = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_a_i,
  input  logic [N-1:0]  src_b_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [N-1:0]  bus_wdata_i,
  output logic [N-1:0]  bus_rdata_o,
  output logic          req0_o,
  output logic          req1_o,
  output logic          wake_o
);
  localparam int NREG   = 7;
  localparam int I_ASN  = 4;
  localparam int I_WAKE = 5;
  localparam int I_MASK = 6;
  localparam logic [AW-1:0] A_RISE_RD  = AW'(4 * NREG);
  localparam logic [AW-1:0] A_RISE_CLR = AW'(4 * NREG + 1);
  localparam logic [AW-1:0] A_FALL_CLR = AW'(4 * NREG + 2);
  localparam logic [AW-1:0] A_FALL_RD  = AW'(4 * NREG + 3);
  localparam logic [AW-1:0] A_PEND0    = AW'(4 * NREG + 4);
  localparam logic [AW-1:0] A_PEND1    = AW'(4 * NREG + 5);
  localparam logic [AW-1:0] A_TEST_RD  = AW'(4 * NREG + 8);
  localparam logic [AW-1:0] A_TEST_WR  = AW'(4 * NREG + 9);

  logic [N-1:0] regs_q [NREG];
  logic [N-1:0] sync1_q, sync2_q, prev_q, rise_q, fall_q;
  logic         test_q;

  // register triplets: read 4k, set 4k+1, clear 4k+2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= (k == I_ASN) ? '1 : '0;
      test_q <= 1'b0;
    end else if (bus_wr_i) begin
      for (int k = 0; k < NREG; k++) begin
        if (bus_addr_i == AW'(4 * k + 1)) regs_q[k] <= regs_q[k] | bus_wdata_i;
        if (bus_addr_i == AW'(4 * k + 2)) regs_q[k] <= regs_q[k] & ~bus_wdata_i;
      end
      if (bus_addr_i == A_TEST_WR) test_q <= bus_wdata_i[0];
    end
  end

  wire [N-1:0] m0 = regs_q[0], m1 = regs_q[1], m2 = regs_q[2];
  wire [N-1:0] sel_a = regs_q[3];
  wire [N-1:0] route0 = regs_q[I_ASN];
  wire [N-1:0] raw = (sel_a & src_a_i) | (~sel_a & src_b_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {sync1_q, sync2_q, prev_q} <= '0;
    else        {sync1_q, sync2_q, prev_q} <= {raw, sync1_q, sync2_q};
  end

  wire [N-1:0] is_r = ~m2 & ~m1 &  m0;
  wire [N-1:0] is_f = ~m2 &  m1 & ~m0;
  wire [N-1:0] is_b = ~m2 &  m1 &  m0;
  wire [N-1:0] is_h =  m2 & ~m1 &  m0;
  wire [N-1:0] is_l =  m2 &  m1 & ~m0;

  wire [N-1:0] rclr = (bus_wr_i && bus_addr_i == A_RISE_CLR) ? bus_wdata_i : '0;
  wire [N-1:0] fclr = (bus_wr_i && bus_addr_i == A_FALL_CLR) ? bus_wdata_i : '0;

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= (rise_q & ~rclr) | ((is_r | is_b) &  sync2_q & ~prev_q);
      fall_q <= (fall_q & ~fclr) | ((is_f | is_b) & ~sync2_q &  prev_q);
    end
  end

  wire [N-1:0] active = (is_r & rise_q) | (is_f & fall_q) | (is_b & (rise_q | fall_q))
                      | (is_h & sync2_q) | (is_l & ~sync2_q);
  wire [N-1:0] pend0 = active & regs_q[I_MASK] & route0;
  wire [N-1:0] pend1 = active & regs_q[I_MASK] & ~route0;

  assign req0_o = |pend0 & ~test_q;
  assign req1_o = |pend1 & ~test_q;
  assign wake_o = |(active & regs_q[I_WAKE]);

  logic [N-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    for (int k = 0; k < NREG; k++)
      if (bus_addr_i == AW'(4 * k)) rd_val = regs_q[k];
    case (bus_addr_i)
      A_RISE_RD: rd_val = rise_q;
      A_FALL_RD: rd_val = fall_q;
      A_PEND0:   rd_val = pend0;
      A_PEND1:   rd_val = pend1;
      A_TEST_RD: rd_val = N'(test_q);
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_val;
  end

  AST_MASK_CLEAR_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == AW'(4 * I_MASK + 2) && &bus_wdata_i) |=> (!req0_o && !req1_o)); // R7
  AST_RISE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(rise_q) & ~rise_q) & ~$past(rclr)) == '0)); // R5
  AST_FALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(fall_q) & ~fall_q) & ~$past(fclr)) == '0)); // R5
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((((m2 & ~m1 & ~m0) | (m2 & m1 & m0) | (~m2 & ~m1 & ~m0)) & (pend0 | pend1)) == '0)); // R6
  AST_TEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    test_q |-> (!req0_o && !req1_o)); // R12
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd_i) |-> $stable(bus_rdata_o)); // R13
endmodule

// File: tb/tb_dual_req_intc.sv
`timescale 1ns/1ps
module tb_dual_req_intc;
  localparam int N = 32;
  localparam logic [5:0] CFG0 = 0, CFG1 = 4, CFG2 = 8, SEL = 12, ASN = 16, WAKE = 20, MASK = 24;
  localparam logic [5:0] RISE_RD = 28, RISE_CLR = 29, FALL_CLR = 30, FALL_RD = 31;
  localparam logic [5:0] PEND0 = 32, PEND1 = 33, TEST_RD = 36, TEST_WR = 37;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_a = '0, src_b = '0, wdata = '0;
  logic wr = 0, rd = 0;
  logic [5:0] addr = '0;
  logic [N-1:0] rdata;
  logic req0, req1, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_req_intc dut (.clk(clk), .rst_n(rst_n), .src_a_i(src_a), .src_b_i(src_b),
    .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .req0_o(req0), .req1_o(req1), .wake_o(wake));

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [5:0] a, logic [N-1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0; wdata = '0;
  endtask

  task automatic rd_reg(logic [5:0] a, output logic [N-1:0] v);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); rd = 0; v = rdata;
  endtask

  task automatic settle(); repeat (5) @(negedge clk); endtask

  task automatic cleanup();
    wr_reg(CFG0 + 2, '1); wr_reg(CFG1 + 2, '1); wr_reg(CFG2 + 2, '1);
    wr_reg(SEL + 2, '1); wr_reg(WAKE + 2, '1); wr_reg(MASK + 2, '1);
    wr_reg(ASN + 1, '1); wr_reg(TEST_WR, '0);
    src_a = '0; src_b = '0; settle();
    wr_reg(RISE_CLR, '1); wr_reg(FALL_CLR, '1); settle();
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R1 req0", N'(req0), 0); check("R1 req1", N'(req1), 0); check("R1 wake", N'(wake), 0);
    for (int k = 0; k < 7; k++) begin
      rd_reg(6'(4 * k), v);
      check("R1 reg", v, (k == 4) ? '1 : '0);
    end
    rd_reg(RISE_RD, v); check("R1 rise latches", v, 0);
    rd_reg(FALL_RD, v); check("R1 fall latches", v, 0);
  endtask

  task automatic t_setclr();
    logic [N-1:0] v;
    wr_reg(CFG2 + 1, 32'h0000_0F0F); wr_reg(CFG2 + 1, 32'h0000_00F0);
    rd_reg(CFG2, v); check("R2 set accumulates", v, 32'h0000_0FFF);
    wr_reg(CFG2 + 2, 32'h0000_000F);
    rd_reg(CFG2, v); check("R2 clear only ones", v, 32'h0000_0FF0);
    @(negedge clk); check("R13 rdata holds", rdata, 32'h0000_0FF0);
    wr_reg(CFG2 + 2, '1);
    rd_reg(CFG2, v); check("R2 clear all", v, 0);
  endtask

  task automatic t_rise();
    logic [N-1:0] v;
    wr_reg(SEL + 1, 32'h1); wr_reg(CFG0 + 1, 32'h1); wr_reg(MASK + 1, 32'h1);
    src_a[0] = 1; settle(); check("R3 rising edge req0", N'(req0), 1);
    src_a[0] = 0; settle(); check("R5 latch holds", N'(req0), 1);
    rd_reg(RISE_RD, v); check("R5 rise latch read", v, 32'h1);
    rd_reg(FALL_RD, v); check("R3 falling not latched in rise mode", v, 0);
    wr_reg(RISE_CLR, 32'h1); settle(); check("R5 rise clear", N'(req0), 0);
  endtask

  task automatic t_fall();
    logic [N-1:0] v;
    wr_reg(SEL + 1, 32'h2); wr_reg(CFG1 + 1, 32'h2); wr_reg(ASN + 2, 32'h2); wr_reg(MASK + 1, 32'h2);
    src_a[1] = 1; settle(); check("R3 rise ignored in fall mode", N'(req1), 0);
    src_a[1] = 0; settle();
    check("R8 routed to req1", N'(req1), 1); check("R8 not on req0", N'(req0), 0);
    rd_reg(PEND1, v); check("R9 pend1 word", v, 32'h2);
    rd_reg(PEND0, v); check("R9 pend0 word", v, 0);
    wr_reg(FALL_CLR, 32'h2); settle(); check("R5 fall clear", N'(req1), 0);
  endtask

  task automatic t_both();
    wr_reg(SEL + 1, 32'h4); wr_reg(CFG0 + 1, 32'h4); wr_reg(CFG1 + 1, 32'h4); wr_reg(MASK + 1, 32'h4);
    src_a[2] = 1; settle(); check("R3 both-edge rise", N'(req0), 1);
    src_a[2] = 0; settle();
    wr_reg(RISE_CLR, 32'h4); settle(); check("R5 both-edge needs fall clear", N'(req0), 1);
    wr_reg(FALL_CLR, 32'h4); settle(); check("R5 both latches cleared", N'(req0), 0);
  endtask

  task automatic t_level();
    wr_reg(CFG0 + 1, 32'h8); wr_reg(CFG2 + 1, 32'h8); wr_reg(MASK + 1, 32'h8);
    src_a[3] = 1; settle(); check("R11 unselected bus ignored", N'(req0), 0);
    src_b[3] = 1; @(negedge clk); @(negedge clk);
    check("R4 high level after sync", N'(req0), 1);
    src_b[3] = 0; settle(); check("R4 high level follows input", N'(req0), 0);
    cleanup();
    wr_reg(CFG1 + 1, 32'h10); wr_reg(CFG2 + 1, 32'h10); wr_reg(MASK + 1, 32'h10); settle();
    check("R4 low level active", N'(req0), 1);
    src_b[4] = 1; settle(); check("R4 low level released", N'(req0), 0);
  endtask

  task automatic try_code(logic [2:0] c);
    logic [N-1:0] v;
    cleanup();
    wr_reg(SEL + 1, 32'h20); wr_reg(MASK + 1, 32'h20);
    if (c[0]) wr_reg(CFG0 + 1, 32'h20);
    if (c[1]) wr_reg(CFG1 + 1, 32'h20);
    if (c[2]) wr_reg(CFG2 + 1, 32'h20);
    src_a[5] = 1; settle(); src_a[5] = 0; settle();
    rd_reg(PEND0, v); check("R6 silent code, input low", v, 0);
    src_a[5] = 1; settle();
    rd_reg(PEND0, v); check("R6 silent code, input high", v, 0);
    check("R6 silent code req0", N'(req0), 0);
  endtask

  task automatic t_mask_wake();
    logic [N-1:0] v;
    wr_reg(SEL + 1, 32'h40); wr_reg(CFG0 + 1, 32'h40); wr_reg(CFG2 + 1, 32'h40);
    wr_reg(WAKE + 1, 32'h40);
    src_a[6] = 1; settle();
    check("R7 masked no req", N'(req0), 0);
    rd_reg(PEND0, v); check("R7 masked not pending", v, 0);
    check("R10 wake ignores mask", N'(wake), 1);
    wr_reg(MASK + 1, 32'h40); settle(); check("R7 unmask raises req", N'(req0), 1);
    wr_reg(WAKE + 2, 32'h40); settle(); check("R10 wake disabled", N'(wake), 0);
  endtask

  task automatic t_test();
    logic [N-1:0] v;
    wr_reg(SEL + 1, 32'h80); wr_reg(CFG0 + 1, 32'h80); wr_reg(CFG2 + 1, 32'h80); wr_reg(MASK + 1, 32'h80);
    src_a[7] = 1; settle(); check("R12 normal mode req", N'(req0), 1);
    wr_reg(TEST_WR, 32'h1); @(negedge clk); check("R12 test mode quiet", N'(req0), 0);
    rd_reg(TEST_RD, v); check("R12 test bit read", v, 32'h1);
    wr_reg(TEST_WR, 32'h0); @(negedge clk); check("R12 back to normal", N'(req0), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_setclr();
    cleanup(); t_rise();
    cleanup(); t_fall();
    cleanup(); t_both();
    cleanup(); t_level();
    try_code(3'b000); try_code(3'b100); try_code(3'b111);
    cleanup(); t_mask_wake();
    cleanup(); t_test();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule